// File: doc/BRIEF.md
# Predictive Output Guard for a Time-Multiplexed FIR Filter

This block sits behind a FIR filter whose datapath may produce occasional large errors, for example when its supply is pushed below the safe level. Each time the filter delivers an output sample, the guard holds an estimate of that sample. The estimate is a short linear prediction built from the most recent outputs the guard itself released. If the sample is further from the estimate than a programmable threshold, the sample is treated as corrupted. The estimate is then released in its place and an error flag is raised.

The estimate comes from a serial multiply-accumulate unit of reduced precision. It advances one tap on every eighth clock of the shared clock, so its critical path can be relaxed well below that of the protected filter. Only the eight upper bits of each 22-bit past output are used as the data operand. The 5-bit coefficients are signed with three fraction bits, and the accumulated sum is shifted back into the 22-bit output format. With one unity tap (coefficient 8) and the other taps zero, the guard compares each sample with the previous released output. Correction only helps when corrupted samples are spaced apart by at least the number of predictor taps.

Top module: `ant_guard`

## Requirements
- R1: `out_vld` is high exactly in the cycle after each cycle with `smp_vld` high, and `out_err` is never high without `out_vld`. After reset all outputs are zero.
- R2: Coefficient slot `coef_sel` (0 to NTAP-1, where slot 0 weights the newest history entry) takes `coef_val` when `coef_we` is high. The value is 5-bit two's complement and means `coef_val`/8. The threshold takes `thr_val` when `thr_we` is high and resets to all ones, so no sample is flagged until a smaller threshold is loaded.
- R3: A free-running 3-bit counter opens the predictor for one cycle in every eight. The predictor adds one tap per opening and finishes its estimate within NTAP*8 cycles after a sample has been taken.
- R4: The estimate is the sum over taps k of coefficient k times bits [21:14] of history entry k (both signed), shifted left by 11 and saturated to the 22-bit signed range [-2097152, 2097151].
- R5: When armed, a sample is flagged if |sample - estimate| is strictly greater than the threshold; a flagged sample is replaced by the estimate. An unflagged sample passes unchanged.
- R6: The history is filled with released (corrected) outputs, newest in entry 0, so a replaced sample does not disturb later estimates.
- R7: Detection is disarmed, and every sample passes with the flag low, until NTAP samples have entered the history since reset. It is also disarmed when a sample arrives before the estimate started by the previous sample is finished; that sample still enters the history and restarts the estimate.
- R8: With coefficient 8 in slot 0 and zero in the other slots, the estimate equals the previous released output with its 14 low bits cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the filter |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Filter output sample valid |
| smp_dat | input | 22 | Filter output sample, two's complement |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Coefficient slot to write |
| coef_val | input | 5 | Coefficient value, signed, three fraction bits |
| thr_we | input | 1 | Threshold write strobe |
| thr_val | input | 22 | Threshold on the residual magnitude |
| out_vld | output | 1 | Released sample valid |
| out_dat | output | 22 | Released sample |
| out_err | output | 1 | Released sample is the estimate, not the filter sample |

## Verification
A wrong history entry, coefficient or accumulator only shows on the sample after the next estimate completes. It appears as a wrong flag or as a released value that differs from the estimate. So each sample's outputs are compared one cycle after it is taken, and a stale internal value shows up within one sample period. A history filled with raw instead of corrected samples shows up as a second, spurious flag right after an injected spike. A fault in the slow enable or tap counter shows up as a missing flag when samples arrive close together.

// File: rtl/ant_pkg.sv
package ant_pkg;
  typedef enum logic [1:0] {
    MAC_IDLE = 2'd0,
    MAC_RUN  = 2'd1,
    MAC_DONE = 2'd2
  } mac_state_e;

  localparam int DEF_SMP_W = 22;
  localparam int DEF_OP_W  = 8;
  localparam int DEF_CF_W  = 5;
  localparam int DEF_ACC_W = 16;
  localparam int DEF_NTAP  = 4;
  localparam int DEF_DIV   = 8;
  localparam int DEF_FRAC  = 3;
endpackage

// File: rtl/ant_slow_tick.sv
module ant_slow_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/ant_hist.sv
module ant_hist #(
  parameter int SMP_W = 22,
  parameter int NTAP  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  logic signed [SMP_W-1:0] din,
  output logic signed [SMP_W-1:0] hist [NTAP],
  output logic                    full
);
  localparam int FILL_W = $clog2(NTAP + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(NTAP);

  logic [FILL_W-1:0] fill;

  for (genvar i = 0; i < NTAP; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        hist[i] <= '0;
      end else if (push) begin
        if (i == 0) hist[i] <= din;
        else        hist[i] <= hist[(i > 0) ? i - 1 : 0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                           fill <= '0;
    else if (push && fill != FILL_MAX) fill <= fill + 1'b1;
  end

  assign full = (fill == FILL_MAX);
endmodule

// File: rtl/ant_pred_mac.sv
module ant_pred_mac
  import ant_pkg::*;
#(
  parameter int SMP_W = 22,
  parameter int OP_W  = 8,
  parameter int CF_W  = 5,
  parameter int ACC_W = 16,
  parameter int NTAP  = 4,
  parameter int FRAC  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    start,
  input  logic                    coef_we,
  input  logic [((NTAP > 1) ? $clog2(NTAP) : 1)-1:0] coef_sel,
  input  logic signed [CF_W-1:0]  coef_val,
  input  logic signed [SMP_W-1:0] hist [NTAP],
  output logic signed [SMP_W-1:0] pred,
  output logic                    ready
);
  localparam int TAP_W = (NTAP > 1) ? $clog2(NTAP) : 1;
  localparam int PR_W  = CF_W + OP_W;
  localparam int SHIFT = SMP_W - OP_W - FRAC;
  localparam int WD    = ACC_W + SHIFT;
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NTAP - 1);
  localparam logic signed [WD-1:0] SMAX = WD'((64'sd1 <<< (SMP_W - 1)) - 64'sd1);
  localparam logic signed [WD-1:0] SMIN = -SMAX - WD'(1);

  logic signed [CF_W-1:0]  cmem [NTAP];
  mac_state_e              st;
  logic [TAP_W-1:0]        idx;
  logic signed [ACC_W-1:0] acc;
  logic signed [OP_W-1:0]  op;
  logic signed [PR_W-1:0]  prod;
  logic signed [ACC_W-1:0] acc_nx;
  logic signed [WD-1:0]    wide;
  logic signed [SMP_W-1:0] sat;

  // coefficient bank: write port only, no reset, read by tap index
  always_ff @(posedge clk) begin
    if (coef_we && (32'(coef_sel) < NTAP)) cmem[coef_sel] <= coef_val;
  end

  always_comb begin
    op     = hist[idx][SMP_W-1 -: OP_W];
    prod   = cmem[idx] * op;
    acc_nx = acc + {{(ACC_W-PR_W){prod[PR_W-1]}}, prod};
    wide   = WD'(acc_nx) <<< SHIFT;
    if (wide > SMAX)      sat = SMAX[SMP_W-1:0];
    else if (wide < SMIN) sat = SMIN[SMP_W-1:0];
    else                  sat = wide[SMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= MAC_IDLE;
      idx  <= '0;
      acc  <= '0;
      pred <= '0;
    end else if (start) begin
      st  <= MAC_RUN;
      idx <= '0;
      acc <= '0;
    end else if (st == MAC_RUN && tick) begin
      acc <= acc_nx;
      if (idx == LAST_TAP) begin
        st   <= MAC_DONE;
        pred <= sat;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign ready = (st == MAC_DONE);
endmodule

// File: rtl/ant_decide.sv
module ant_decide #(
  parameter int SMP_W = 22
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp_dat,
  input  logic signed [SMP_W-1:0] pred,
  input  logic [SMP_W-1:0]        thr,
  input  logic                    armed,
  output logic signed [SMP_W-1:0] corr,
  output logic                    out_vld,
  output logic signed [SMP_W-1:0] out_dat,
  output logic                    out_err
);
  logic signed [SMP_W:0] res;
  logic [SMP_W:0]        mag;
  logic                  hit;

  always_comb begin
    res  = {smp_dat[SMP_W-1], smp_dat} - {pred[SMP_W-1], pred};
    mag  = res[SMP_W] ? -res : res;
    hit  = armed && (mag > {1'b0, thr});
    corr = hit ? pred : smp_dat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_dat <= '0;
      out_err <= 1'b0;
    end else begin
      out_vld <= smp_vld;
      out_err <= smp_vld && hit;
      if (smp_vld) out_dat <= corr;
    end
  end
endmodule

// File: rtl/ant_guard.sv
module ant_guard
  import ant_pkg::*;
#(
  parameter int SMP_W = DEF_SMP_W,
  parameter int OP_W  = DEF_OP_W,
  parameter int CF_W  = DEF_CF_W,
  parameter int ACC_W = DEF_ACC_W,
  parameter int NTAP  = DEF_NTAP,
  parameter int DIV   = DEF_DIV,
  parameter int FRAC  = DEF_FRAC,
  localparam int TAP_W = (NTAP > 1) ? $clog2(NTAP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_dat,
  input  logic             coef_we,
  input  logic [TAP_W-1:0] coef_sel,
  input  logic [CF_W-1:0]  coef_val,
  input  logic             thr_we,
  input  logic [SMP_W-1:0] thr_val,
  output logic             out_vld,
  output logic [SMP_W-1:0] out_dat,
  output logic             out_err
);
  logic                    slow_tick;
  logic                    hist_full;
  logic                    pred_rdy;
  logic signed [SMP_W-1:0] hist [NTAP];
  logic signed [SMP_W-1:0] pred_q;
  logic signed [SMP_W-1:0] corr;
  logic signed [SMP_W-1:0] dat_q;
  logic [SMP_W-1:0]        thr_q;

  always_ff @(posedge clk) begin
    if (rst)         thr_q <= '1;
    else if (thr_we) thr_q <= thr_val;
  end

  ant_slow_tick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(slow_tick)
  );

  ant_hist #(.SMP_W(SMP_W), .NTAP(NTAP)) u_hist (
    .clk (clk),
    .rst (rst),
    .push(smp_vld),
    .din (corr),
    .hist(hist),
    .full(hist_full)
  );

  ant_pred_mac #(
    .SMP_W(SMP_W), .OP_W(OP_W), .CF_W(CF_W),
    .ACC_W(ACC_W), .NTAP(NTAP), .FRAC(FRAC)
  ) u_mac (
    .clk     (clk),
    .rst     (rst),
    .tick    (slow_tick),
    .start   (smp_vld),
    .coef_we (coef_we),
    .coef_sel(coef_sel),
    .coef_val(coef_val),
    .hist    (hist),
    .pred    (pred_q),
    .ready   (pred_rdy)
  );

  ant_decide #(.SMP_W(SMP_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .smp_vld(smp_vld),
    .smp_dat(smp_dat),
    .pred   (pred_q),
    .thr    (thr_q),
    .armed  (hist_full && pred_rdy),
    .corr   (corr),
    .out_vld(out_vld),
    .out_dat(dat_q),
    .out_err(out_err)
  );

  assign out_dat = dat_q;
endmodule

// File: rtl/ant_guard_chk.sv
module ant_guard_chk #(
  parameter int SMP_W = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_vld,
  input logic [SMP_W-1:0] smp_dat,
  input logic             out_vld,
  input logic [SMP_W-1:0] out_dat,
  input logic             out_err,
  input logic             tick,
  input logic [SMP_W-1:0] pred,
  input logic             ready,
  input logic             fill_done
);
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> out_vld); // R1
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !out_vld); // R1
  AST_ERR_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_vld); // R1
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R3
  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> (out_err || out_dat == $past(smp_dat))); // R5
  AST_SUBST_ESTIMATE: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> (!out_err || out_dat == $past(pred))); // R5
  AST_DISARMED_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !(ready && fill_done)) |=> !out_err); // R7
endmodule

bind ant_guard ant_guard_chk #(.SMP_W(SMP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_vld  (smp_vld),
  .smp_dat  (smp_dat),
  .out_vld  (out_vld),
  .out_dat  (out_dat),
  .out_err  (out_err),
  .tick     (slow_tick),
  .pred     (pred_q),
  .ready    (pred_rdy),
  .fill_done(hist_full)
);

// File: tb/sim_ant_guard.sv
module sim_ant_guard;
  localparam int SMP_W = 22;
  localparam int NTAP  = 4;
  localparam longint SMAXV = 2097151;
  localparam longint SMINV = -2097152;
  localparam longint READY_GAP = 33;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             smp_vld = 1'b0;
  logic [SMP_W-1:0] smp_dat = '0;
  logic             coef_we = 1'b0;
  logic [1:0]       coef_sel = '0;
  logic [4:0]       coef_val = '0;
  logic             thr_we = 1'b0;
  logic [SMP_W-1:0] thr_val = '0;
  logic             out_vld;
  logic [SMP_W-1:0] out_dat;
  logic             out_err;

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     done = 0;

  longint hist_m [NTAP];
  longint coef_m [NTAP];
  longint thr_m;
  longint pred_m;
  int     fill_m;
  longint last_push;
  bit     have_push;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ant_guard u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_dat(smp_dat),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_val(coef_val),
    .thr_we(thr_we), .thr_val(thr_val),
    .out_vld(out_vld), .out_dat(out_dat), .out_err(out_err)
  );

  function automatic longint sx22(logic [SMP_W-1:0] v);
    return longint'(signed'(v));
  endfunction

  function automatic longint clamp22(longint v);
    if (v > SMAXV) return SMAXV;
    if (v < SMINV) return SMINV;
    return v;
  endfunction

  function automatic longint estimate();
    longint s = 0;
    for (int k = 0; k < NTAP; k++) s += coef_m[k] * (hist_m[k] >>> 14);
    return clamp22(s * 2048);
  endfunction

  task automatic check(string tag, longint act, longint exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NTAP; k++) hist_m[k] = 0;
    fill_m = 0;
    have_push = 0;
    thr_m = SMAXV * 2 + 1;
    pred_m = 0;
  endtask

  task automatic set_coef(int k, int v);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = 2'(k); coef_val = 5'(v);
    @(negedge clk);
    coef_we = 1'b0;
    coef_m[k] = longint'(v);
  endtask

  task automatic set_thr(longint v);
    @(negedge clk);
    thr_we = 1'b1; thr_val = SMP_W'(v);
    @(negedge clk);
    thr_we = 1'b0;
    thr_m = v;
  endtask

  // sends one sample, checks it, then idles gap cycles
  task automatic send(longint v, int gap, string tag);
    longint exp_out, res, mag;
    bit     armed, exp_err;
    longint edge_now;
    @(negedge clk);
    smp_vld = 1'b1; smp_dat = SMP_W'(v);
    edge_now = cyc + 1;
    armed = (fill_m >= NTAP) && have_push && (edge_now - last_push >= READY_GAP);
    res = v - pred_m;
    mag = (res < 0) ? -res : res;
    exp_err = armed && (mag > thr_m);
    exp_out = exp_err ? pred_m : v;
    @(negedge clk);
    smp_vld = 1'b0;
    check(tag, longint'(out_vld), 1, "out_vld");
    check(tag, longint'(out_err), longint'(exp_err), "out_err");
    check(tag, sx22(out_dat), exp_out, "out_dat");
    for (int k = NTAP - 1; k > 0; k--) hist_m[k] = hist_m[k-1];
    hist_m[0] = exp_out;
    if (fill_m < NTAP) fill_m++;
    last_push = edge_now;
    have_push = 1;
    pred_m = estimate();
    repeat (gap) @(negedge clk);
    if (gap > 0) check(tag, longint'(out_vld), 0, "out_vld idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint cur, v;
    void'($urandom(32'd20240917));
    for (int k = 0; k < NTAP; k++) coef_m[k] = 0;
    do_reset();
    // R1 reset state
    check("R1", longint'(out_vld), 0, "reset out_vld");
    check("R1", longint'(out_err), 0, "reset out_err");
    check("R1", sx22(out_dat), 0, "reset out_dat");

    // R2/R8 difference mode, default threshold flags nothing
    set_coef(0, 8); set_coef(1, 0); set_coef(2, 0); set_coef(3, 0);
    for (int i = 0; i < 5; i++) send(longint'(i) * 16384, 40, "R2");
    send(1900000, 40, "R2");          // huge jump, threshold still all ones
    check("R2", longint'(out_err), 0, "default threshold");

    // R7 warm-up after reset: low threshold, first NTAP samples pass
    do_reset();
    set_thr(1000);
    for (int i = 0; i < NTAP; i++) send(500000 + longint'(i) * 1000, 40, "R7");
    // R8 prediction is previous output with low bits cleared
    send(503000 + 200, 40, "R8");     // estimate 491520, residual > 1000 -> flagged
    check("R8", sx22(out_dat), (longint'(503000) >>> 14) * 16384, "difference estimate");

    // R5 strict threshold boundary
    do_reset();
    set_thr(5000);
    for (int i = 0; i < NTAP; i++) send(163840, 40, "R5");
    send(163840 + 5000, 40, "R5");    // equal to threshold: passes
    send(163840 + 5001, 40, "R5");    // one above: replaced by 163840
    send(163840 - 5001, 40, "R5");

    // R6 spike replaced, next normal sample not flagged
    send(163840 + 600000, 40, "R6");
    send(163840 + 100, 40, "R6");
    check("R6", longint'(out_err), 0, "after spike");

    // R7 sample arriving before estimate is ready
    send(163840, 1, "R7");
    send(163840 + 900000, 40, "R7");  // not ready: passes unflagged
    send(163840 + 900000, 40, "R7");

    // R4 saturation both ways
    do_reset();
    set_coef(0, 15); set_coef(1, 15); set_coef(2, 15); set_coef(3, 15);
    for (int i = 0; i < NTAP; i++) send(SMAXV, 40, "R4");
    set_thr(0);
    send(SMINV, 40, "R4");            // estimate saturates high
    do_reset();
    set_coef(0, -16); set_coef(1, -16); set_coef(2, -16); set_coef(3, -16);
    for (int i = 0; i < NTAP; i++) send(SMAXV, 40, "R4");
    set_thr(0);
    send(SMAXV, 40, "R4");            // estimate saturates low

    // R3/R4/R5 random: smooth walk with spaced spikes, mixed coefficients
    do_reset();
    set_coef(0, 12); set_coef(1, -4); set_coef(2, 0); set_coef(3, 0);
    set_thr(30000);
    cur = 0;
    for (int i = 0; i < 160; i++) begin
      if (i == 80) begin
        for (int k = 0; k < NTAP; k++) set_coef(k, int'($urandom_range(0, 31)) - 16);
        set_thr(longint'($urandom_range(0, 200000)));
      end
      cur = cur + longint'($urandom_range(0, 8191)) - 4096;
      if (cur > 1500000) cur = 1500000;
      if (cur < -1500000) cur = -1500000;
      v = cur;
      if (i % 7 == 3) v = clamp22(cur + (($urandom_range(0, 1) != 0) ? 1048576 : -1048576));
      send(v, ($urandom_range(0, 9) == 0) ? 1 : 31 + int'($urandom_range(0, 20)), "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule